// File: doc/BRIEF.md
# Programmable Pixel Color Matrix

This block maps each 24-bit pixel, made of three 8-bit channels, into another color space with a programmable 3×4 matrix. Every output channel is the weighted sum of the three input channels plus a per-row offset. The sum is rounded to the nearest integer and clamped to the 8-bit range. Typical uses are YCrCb-to-RGB and RGB-to-YCrCb conversion in a display pipeline.

Pixels stream in with a valid flag and leave a fixed number of cycles later with the valid flag delayed to match. The twelve 13-bit matrix entries are loaded one byte at a time through a small write port. The upper five bits of an entry are staged first. The entry only changes when its lower byte is written, so the datapath never sees a half-written value.

Top module: `pix_matrix_xform`

## Requirements
- R1: For output channel k (k = 0, 1, 2), out_k = clamp(round((M[4k]·x0 + M[4k+1]·x1 + M[4k+2]·x2 + M[4k+3]·256) / 2048)). Here x0 = in_pix[23:16], x1 = in_pix[15:8] and x2 = in_pix[7:0]. out_k is placed in out_pix at the same bit slice as x_k.
- R2: Each matrix entry M[i] is a 13-bit two's-complement number. For the three gain terms, 0x0800 means a gain of 1.0 (11 fraction bits). An offset entry M[4k+3] has three fraction bits, so one of its steps is 1/8 of an output step.
- R3: Rounding is to the nearest integer. An exact half rounds upward, which is floor(sum/2048 + 0.5).
- R4: A result below 0 gives 0 and a result above 255 gives 255.
- R5: out_valid equals in_valid from three clock edges earlier. When out_valid is high, out_pix carries the result for that pixel. After reset, out_valid and out_pix are 0.
- R6: A write with cfg_we=1 and cfg_hi=1 stores cfg_byte[4:0] as the staged upper bits of entry cfg_idx and does not change the output. A write with cfg_hi=0 sets entry cfg_idx to {staged bits, cfg_byte}.
- R7: Writes with cfg_idx from 12 to 15 change no entry and no staged bits.
- R8: The reset values are M[0]=0x0C00, M[1]=0x0800, M[2]=0x0000, M[3]=0x19D7, M[5]=0x0800 and M[10]=0x0800. All other entries are 0.
- R9: Each entry's staged upper bits reset to the upper five bits of its reset value and keep their value after a low-byte write. A low-byte write with no high-byte write before it therefore reuses the last staged bits.
- R10: A pixel accepted on the same clock edge as a low-byte write uses the old entry. A pixel accepted on the next edge uses the new entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input pixel valid |
| in_pix | input | 24 | Input pixel: x0 in [23:16], x1 in [15:8], x2 in [7:0] |
| cfg_we | input | 1 | Matrix byte write strobe |
| cfg_idx | input | 4 | Entry index, 4·row + term; term 3 is the offset |
| cfg_hi | input | 1 | 1 = upper-bits byte (staged), 0 = lower byte (commits) |
| cfg_byte | input | 8 | Write data |
| out_valid | output | 1 | Output pixel valid |
| out_pix | output | 24 | Converted pixel, same channel layout as in_pix |

## Verification
Full 0..255 ramps are run on each channel through several matrices:
- The reset matrix, whose negative offset tests signed offset alignment.
- A channel permutation, which catches swapped term or channel indexing.
- Half-unity gains, which give exact .5 results on odd inputs and so separate round-half-up from truncation.
- Near-2.0 and −1.0 gains, which drive results past both clamp limits.

Several pseudo-random full matrices with random pixels then test the general sign and width handling. Short bursts test the write port: between high-byte and low-byte writes, after lone low-byte writes, after writes to unused indexes, and on the exact edge of a commit. Gaps in in_valid show that the valid delay tracks each pixel.

// File: rtl/pmx_pkg.sv
// pmx_pkg: shared sizes and reset matrix of the pixel color matrix.
// Assumes three channels and a 4-term row (three gains plus one offset).
package pmx_pkg;
    localparam int CH_W       = 8;
    localparam int N_CH       = 3;
    localparam int N_TERM     = N_CH + 1;
    localparam int N_COEF     = N_CH * N_TERM;
    localparam int IDX_W      = 4;
    localparam int COEF_W     = 13;
    localparam int LO_W       = 8;
    localparam int HI_W       = COEF_W - LO_W;
    localparam int FRAC_W     = 11;
    localparam int OFF_FRAC_W = 3;
    localparam int LAT        = 3;
    localparam int PIX_W      = N_CH * CH_W;

    typedef logic [COEF_W-1:0] coef_t;

    // Reset value of matrix entry idx (index = 4*row + term).
    function automatic coef_t pmx_default(input int idx);
        case (idx)
            0:       return coef_t'(13'h0C00);
            1:       return coef_t'(13'h0800);
            3:       return coef_t'(13'h19D7);
            5:       return coef_t'(13'h0800);
            10:      return coef_t'(13'h0800);
            default: return coef_t'(0);
        endcase
    endfunction
endpackage

// File: rtl/pmx_coef_bank.sv
// pmx_coef_bank: holds the twelve matrix entries and their staged upper bits.
// The upper bits are staged on a high-byte write. The entry changes only on a
// low-byte write. Indexes at or above N_COEF match no entry.
module pmx_coef_bank
    import pmx_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [IDX_W-1:0]         cfg_idx,
    input  logic                     cfg_hi,
    input  logic [LO_W-1:0]          cfg_byte,
    output logic [N_COEF*COEF_W-1:0] coef_flat
);
    logic [N_COEF*HI_W-1:0] stage_flat;

    generate
        for (genvar i = 0; i < N_COEF; i++) begin : g_entry
            localparam coef_t DEF = pmx_default(i);
            logic              sel;
            logic [HI_W-1:0]   stage_q;
            logic [COEF_W-1:0] act_q;

            assign sel = cfg_we && (cfg_idx == IDX_W'(i));

            // Stage upper bits on a high write; commit the whole entry on a low write.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage_q <= DEF[COEF_W-1:LO_W];
                    act_q   <= DEF;
                end else if (sel) begin
                    if (cfg_hi) stage_q <= cfg_byte[HI_W-1:0];
                    else        act_q   <= {stage_q, cfg_byte};
                end
            end

            assign coef_flat[i*COEF_W +: COEF_W] = act_q;
            assign stage_flat[i*HI_W +: HI_W]    = stage_q;
        end
    endgenerate

    // R6
    hi_write_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_hi) |=> $stable(coef_flat));

    // R6
    lo_write_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_hi && (cfg_idx < IDX_W'(N_COEF)))
        |=> (coef_flat[$past(cfg_idx)*COEF_W +: LO_W] == $past(cfg_byte)));

    // R7
    unused_idx_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (cfg_idx >= IDX_W'(N_COEF)))
        |=> ($stable(coef_flat) && $stable(stage_flat)));
endmodule

// File: rtl/pmx_row.sv
// pmx_row: one output channel. Stage 1 forms the three signed products and
// the aligned offset. Stage 2 sums them with the rounding constant. Stage 3
// shifts and clamps to 0..255. Assumes the coefficients are stable or
// updated atomically.
module pmx_row
    import pmx_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [PIX_W-1:0]         pix,
    input  logic [N_TERM*COEF_W-1:0] row_coef,
    output logic [CH_W-1:0]          ch_out
);
    localparam int PROD_W = COEF_W + CH_W + 1;
    localparam int ACC_W  = PROD_W + $clog2(N_TERM) + 1;
    localparam int OFF_SH = FRAC_W - OFF_FRAC_W;
    localparam logic signed [ACC_W-1:0] RND = ACC_W'(1) <<< (FRAC_W - 1);
    localparam logic [CH_W-1:0] CH_MAX = {CH_W{1'b1}};

    logic [N_CH*PROD_W-1:0]   prod_flat;
    logic signed [ACC_W-1:0]  off_q;
    logic signed [ACC_W-1:0]  acc_d;
    logic signed [ACC_W-1:0]  sum_q;
    logic signed [ACC_W-1:0]  shifted;
    logic [CH_W-1:0]          clamp_d;

    generate
        for (genvar j = 0; j < N_CH; j++) begin : g_term
            logic signed [PROD_W-1:0] p_q;
            // Stage 1: signed gain times unsigned channel value.
            always_ff @(posedge clk) begin
                if (!rst_n) p_q <= '0;
                else        p_q <= $signed(row_coef[j*COEF_W +: COEF_W])
                                 * $signed({1'b0, pix[(N_CH-1-j)*CH_W +: CH_W]});
            end
            assign prod_flat[j*PROD_W +: PROD_W] = p_q;
        end
    endgenerate

    // Stage 1: sign-extend the offset and align it with the product scale.
    always_ff @(posedge clk) begin
        if (!rst_n) off_q <= '0;
        else        off_q <= {{(ACC_W-COEF_W){row_coef[N_TERM*COEF_W-1]}},
                              row_coef[N_CH*COEF_W +: COEF_W]} <<< OFF_SH;
    end

    // Stage 2 adder: products, offset and half-step rounding constant.
    always_comb begin
        acc_d = off_q + RND;
        for (int j = 0; j < N_CH; j++) begin
            acc_d = acc_d + {{(ACC_W-PROD_W){prod_flat[j*PROD_W+PROD_W-1]}},
                             prod_flat[j*PROD_W +: PROD_W]};
        end
    end

    // Stage 2: register the rounded sum.
    always_ff @(posedge clk) begin
        if (!rst_n) sum_q <= '0;
        else        sum_q <= acc_d;
    end

    // Stage 3 logic: drop the fraction and saturate to the channel range.
    always_comb begin
        shifted = sum_q >>> FRAC_W;
        if (shifted[ACC_W-1])             clamp_d = '0;
        else if (|shifted[ACC_W-2:CH_W])  clamp_d = CH_MAX;
        else                              clamp_d = shifted[CH_W-1:0];
    end

    // Stage 3: register the channel result.
    always_ff @(posedge clk) begin
        if (!rst_n) ch_out <= '0;
        else        ch_out <= clamp_d;
    end

    // R4
    neg_sum_clamps_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sum_q[ACC_W-1] |=> (ch_out == '0));

    // R4
    big_sum_clamps_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sum_q[ACC_W-1] && (sum_q >= (ACC_W'(1) <<< (FRAC_W + CH_W)))) |=> (ch_out == CH_MAX));
endmodule

// File: rtl/pix_matrix_xform.sv
// pix_matrix_xform: streaming 3x4 color matrix. It has one coefficient bank
// and one row pipeline per output channel, and a valid flag delayed by LAT.
// Assumes in_pix is only meaningful while in_valid is high.
module pix_matrix_xform
    import pmx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [PIX_W-1:0]  in_pix,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic              cfg_hi,
    input  logic [LO_W-1:0]   cfg_byte,
    output logic              out_valid,
    output logic [PIX_W-1:0]  out_pix
);
    localparam int CNT_W = $clog2(LAT + 1);

    logic [N_COEF*COEF_W-1:0] coef_flat;
    logic [LAT-1:0]           vpipe_q;

    pmx_coef_bank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_idx   (cfg_idx),
        .cfg_hi    (cfg_hi),
        .cfg_byte  (cfg_byte),
        .coef_flat (coef_flat)
    );

    generate
        for (genvar k = 0; k < N_CH; k++) begin : g_row
            pmx_row u_row (
                .clk      (clk),
                .rst_n    (rst_n),
                .pix      (in_pix),
                .row_coef (coef_flat[k*N_TERM*COEF_W +: N_TERM*COEF_W]),
                .ch_out   (out_pix[(N_CH-1-k)*CH_W +: CH_W])
            );
        end
    endgenerate

    // Valid delay line matching the datapath depth.
    always_ff @(posedge clk) begin
        if (!rst_n) vpipe_q <= '0;
        else        vpipe_q <= {vpipe_q[LAT-2:0], in_valid};
    end
    assign out_valid = vpipe_q[LAT-1];

    // Count edges since reset so the latency check never looks before reset.
    logic [CNT_W-1:0] since_rst_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                         since_rst_q <= '0;
        else if (since_rst_q != CNT_W'(LAT)) since_rst_q <= since_rst_q + 1'b1;
    end

    // R5
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst_q == CNT_W'(LAT)) |-> (out_valid == $past(in_valid, 3)));

    // R5
    valid_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst_q == '0) |-> !out_valid);
endmodule

// File: tb/pix_matrix_xform_tb.sv
`timescale 1ns/1ps
module pix_matrix_xform_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [23:0] in_pix = '0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic        cfg_hi = 1'b0;
    logic [7:0]  cfg_byte = '0;
    logic        out_valid;
    logic [23:0] out_pix;

    int vecs = 0;
    int fails = 0;
    bit done = 0;
    string cur_tag = "R1";

    // bench model: entries, staged upper bits, and the three-deep pipeline
    int act[12];
    int stg[12];
    bit pv[3];
    logic [23:0] pe[3];
    string pt[3];
    logic [31:0] seed = 32'h1234_5678;

    always #4 clk = ~clk;

    pix_matrix_xform u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_hi(cfg_hi), .cfg_byte(cfg_byte),
        .out_valid(out_valid), .out_pix(out_pix)
    );

    function automatic int sx(input int v);
        return (v >= 4096) ? v - 8192 : v;
    endfunction

    // R1 R2 R3 R4: arithmetic reference for one pixel
    function automatic logic [23:0] model(input logic [23:0] p);
        logic [23:0] r;
        int x[3];
        x[0] = int'(p[23:16]); x[1] = int'(p[15:8]); x[2] = int'(p[7:0]);
        for (int k = 0; k < 3; k++) begin
            int s;
            int q;
            s = sx(act[4*k])*x[0] + sx(act[4*k+1])*x[1] + sx(act[4*k+2])*x[2]
              + sx(act[4*k+3])*256;
            q = (s + 1024) >>> 11;
            if (q < 0) q = 0;
            if (q > 255) q = 255;
            r[(2-k)*8 +: 8] = q[7:0];
        end
        return r;
    endfunction

    function automatic logic [31:0] rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed;
    endfunction

    // One cycle: check the output due now, then drive pixel and cfg write.
    task automatic step(input bit v, input logic [23:0] pix,
                        input bit we, input int idx, input bit hi, input logic [7:0] b);
        @(negedge clk);
        vecs++;
        if (pv[2]) begin
            if (out_valid !== 1'b1 || out_pix !== pe[2]) begin
                fails++;
                $display("FAIL %s: out_valid=%0b out_pix=%06h expected out_valid=1 out_pix=%06h",
                         pt[2], out_valid, out_pix, pe[2]);
            end
        end else if (out_valid !== 1'b0) begin
            fails++;
            $display("FAIL %s (R5): out_valid=%0b expected 0", pt[2], out_valid);
        end
        pv[2] = pv[1]; pe[2] = pe[1]; pt[2] = pt[1];
        pv[1] = pv[0]; pe[1] = pe[0]; pt[1] = pt[0];
        pv[0] = v; pe[0] = model(pix); pt[0] = cur_tag;
        if (we && idx < 12) begin
            if (hi) stg[idx] = int'(b[4:0]);
            else    act[idx] = stg[idx] * 256 + int'(b);
        end
        in_valid = v; in_pix = pix;
        cfg_we = we; cfg_idx = idx[3:0]; cfg_hi = hi; cfg_byte = b;
    endtask

    task automatic flush();
        for (int i = 0; i < 3; i++) step(0, 24'h0, 0, 0, 0, 8'h0);
    endtask

    task automatic wr(input int idx, input int val);
        step(0, 24'h0, 1, idx, 1, 8'((val >> 8) & 8'hFF));
        step(0, 24'h0, 1, idx, 0, 8'(val & 8'hFF));
    endtask

    task automatic load(input int m[12]);
        for (int i = 0; i < 12; i++) wr(i, m[i]);
    endtask

    // Ramp over every channel value with decorrelated companions.
    task automatic sweep(input int gap);
        for (int i = 0; i < 256; i++) begin
            logic [7:0] a, c, d;
            a = 8'(i); c = 8'(255 - i); d = 8'(i * 37 + 11);
            step((gap == 0) || (i % gap != 0), {a, c, d}, 0, 0, 0, 8'h0);
        end
        for (int i = 0; i < 256; i++) begin
            logic [7:0] a, c, d;
            a = 8'(i * 91); c = 8'(i); d = 8'(255 - i);
            step(1, {a, c, d}, 0, 0, 0, 8'h0);
        end
        for (int i = 0; i < 256; i++) begin
            logic [7:0] a, c, d;
            a = 8'(255 - i); c = 8'(i * 13 + 5); d = 8'(i);
            step(1, {a, c, d}, 0, 0, 0, 8'h0);
        end
        flush();
    endtask

    initial begin
        int m[12];
        act = '{13'h0C00, 13'h0800, 0, 13'h19D7, 0, 13'h0800, 0, 0, 0, 0, 13'h0800, 0};
        for (int i = 0; i < 12; i++) stg[i] = act[i] >> 8;
        for (int i = 0; i < 3; i++) begin pv[i] = 0; pe[i] = '0; pt[i] = "R5"; end

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R5: reset state of the outputs
        vecs++;
        if (out_valid !== 1'b0 || out_pix !== 24'h0) begin
            fails++;
            $display("FAIL R5: after reset out_valid=%0b out_pix=%06h expected 0 000000",
                     out_valid, out_pix);
        end

        // R8: reset matrix, including the negative offset
        cur_tag = "R8"; sweep(0);

        // R9: lone low write combines with reset-staged upper bits
        cur_tag = "R9"; step(0, 24'h0, 1, 3, 0, 8'h40); sweep(0);

        // R1 R2: channel permutation
        cur_tag = "R1";
        m = '{0, 0, 13'h0800, 0, 13'h0800, 0, 0, 0, 0, 13'h0800, 0, 0};
        load(m); sweep(5);

        // R2: signed gains and offsets of both signs
        cur_tag = "R2";
        m = '{13'h0500, 13'h1E00, 13'h0133, 13'h0040, 13'h1F80, 13'h0700, 13'h1FF0, 13'h1FC0,
              13'h0066, 13'h1D00, 13'h0A00, 13'h00F0};
        load(m); sweep(0);

        // R3: half gains produce exact .5 results on odd inputs
        cur_tag = "R3";
        m = '{13'h0400, 0, 0, 0, 0, 13'h0400, 0, 13'h0004, 0, 0, 13'h0401, 13'h1FFC};
        load(m); sweep(0);

        // R4: saturation at both ends
        cur_tag = "R4";
        m = '{13'h0FFF, 13'h0FFF, 13'h0FFF, 0, 13'h1800, 0, 0, 13'h0100,
              13'h0800, 13'h1800, 0, 13'h0FFF};
        load(m); sweep(0);

        // R1: pseudo-random matrices and pixels
        cur_tag = "R1";
        for (int r = 0; r < 6; r++) begin
            for (int i = 0; i < 12; i++) m[i] = int'(rnd() >> 19) & 13'h1FFF;
            load(m);
            for (int i = 0; i < 256; i++) step(1, 24'(rnd() >> 8), 0, 0, 0, 8'h0);
            flush();
        end

        // R6: staged upper bits leave the output untouched until the low write
        cur_tag = "R6";
        step(0, 24'h0, 1, 0, 1, 8'hE3);
        for (int i = 0; i < 40; i++) step(1, 24'(rnd() >> 8), 0, 0, 0, 8'h0);
        step(0, 24'h0, 1, 0, 0, 8'h21);
        for (int i = 0; i < 40; i++) step(1, 24'(rnd() >> 8), 0, 0, 0, 8'h0);

        // R9: a second low write reuses the staged bits
        cur_tag = "R9";
        step(0, 24'h0, 1, 0, 0, 8'h9C);
        for (int i = 0; i < 40; i++) step(1, 24'(rnd() >> 8), 0, 0, 0, 8'h0);

        // R7: unused indexes change nothing
        cur_tag = "R7";
        for (int j = 12; j < 16; j++) begin
            step(0, 24'h0, 1, j, 1, 8'h1F);
            step(0, 24'h0, 1, j, 0, 8'hA5);
        end
        for (int i = 0; i < 40; i++) step(1, 24'(rnd() >> 8), 0, 0, 0, 8'h0);
        flush();

        // R10: commit edge versus pixel edge
        cur_tag = "R10";
        step(0, 24'h0, 1, 4, 1, 8'h06);
        for (int i = 0; i < 8; i++) begin
            step(1, {8'(i * 30), 8'(200 - i), 8'(i)}, 1, 4, 0, 8'(i * 29));
            step(1, {8'(i * 30), 8'(200 - i), 8'(i)}, 0, 0, 0, 8'h0);
        end
        flush();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
            $finish;
        end
    end
endmodule